// File: doc/BRIEF.md
# DDR Power-Down Sequencer

This block sits in a DDR SDRAM controller beside the access engine and owns the clock-enable pin during low-power periods. When the host logic asks for power-down and the access engine reports no access in flight, the sequencer drives CKE low behind a NOP. It holds the command bus at DESELECT while the device sleeps, and it brings the device back out with CKE high and a NOP. It records whether any bank had an open row at the moment of entry, so the host can tell active power-down from precharge power-down.

An optional path turns the device DLL off before entry and back on after exit. The sequencer only raises one-cycle request pulses for the mode-register writes; the host's command path issues them. After the DLL is switched back on, READ commands are blocked for a parameterised lock period of 200 cycles by default. The sequencer leaves power-down early when a refresh falls due or when a programmable residency limit runs out, even if the request is still held.

Top module: `ddr_pd_seq`

## Requirements
- R1: After reset, cke is 1, cmd_ctl is PASS (2'b00), pd_active is 0, cmd_ready is 1, read_allowed is 1, and both DLL request pulses are 0.
- R2: When pd_req is 1, engine_busy is 0 and refresh_due is 0 at a rising edge in the idle state and dll_off_en is 0, then from that edge cke is 0, cmd_ctl is NOP (2'b01) and pd_active is 1.
- R3: A request that meets engine_busy high is held and not dropped. cke stays 1 while busy is seen, and falls at the first edge where busy is seen low.
- R4: pd_type takes the OR of bank_open sampled at the edge that drives cke low (1 = some row open, active power-down; 0 = all idle, precharge power-down). It holds that value while powered down, whatever bank_open does afterwards.
- R5: From one cycle after entry until exit, cke is 0, cmd_ctl is DESELECT (2'b10), cmd_ready is 0 and read_allowed is 0.
- R6: When pd_req is seen low while powered down, cke is 1 with cmd_ctl NOP and pd_active 0 from the next edge. One edge later, cmd_ctl returns to PASS and cmd_ready is 1.
- R7: refresh_due high forces the same exit as R6 while pd_req stays 1, and it prevents entry from the idle state for as long as it is high.
- R8: With max_resid = M > 0 and the request held, cke stays low for exactly M+1 cycles (entry cycle plus M). With max_resid = 0, there is no residency limit.
- R9: With dll_off_en = 1 at acceptance, the next cycle raises dll_off_req for exactly one cycle, with cke still 1, cmd_ready 1 and read_allowed 0. Entry as in R2 follows at the first edge that sees engine_busy low.
- R10: After an exit that followed a DLL-off entry, dll_on_req pulses for one cycle in the cycle after the exit NOP. read_allowed stays 0 for LOCK_CYCLES cycles counted from that pulse cycle, and is 1 after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, kept running in power-down |
| rst_n | input | 1 | Active-low synchronous reset |
| pd_req | input | 1 | Host request to stay powered down |
| engine_busy | input | 1 | Access engine has an access in progress |
| bank_open | input | NUM_BANKS | Per-bank open-row bitmap |
| refresh_due | input | 1 | Refresh must be serviced; forces exit, blocks entry |
| dll_off_en | input | 1 | Use the DLL-off path for this entry |
| max_resid | input | RESID_W | Maximum power-down cycles, 0 = unlimited |
| cke | output | 1 | Registered clock-enable to the device |
| cmd_ctl | output | 2 | Command bus control: 00 PASS, 01 NOP, 10 DESELECT |
| dll_off_req | output | 1 | One-cycle request to write DLL disable |
| dll_on_req | output | 1 | One-cycle request to write DLL enable |
| pd_active | output | 1 | Device is in or entering power-down |
| pd_type | output | 1 | 0 precharge power-down, 1 active power-down |
| read_allowed | output | 1 | READ commands may be issued |
| cmd_ready | output | 1 | Host commands may use the bus |

## Verification
Every result of a sampled input is registered once, so entry, the exit NOP and the DLL pulses appear one edge after the deciding sample. cmd_ready and the return to PASS come one edge after the exit NOP. The bench drives on the falling edge and checks at the next falling edge, which is exactly one rising edge later. For multi-cycle results such as residency and the read lockout, it counts falling edges from the known first cycle and compares the count with M+1 or LOCK_CYCLES. Sweeps cover all bank bitmaps, several busy hold lengths and several residency limits.

// File: rtl/ddr_pd_pkg.sv
package ddr_pd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DLL_OFF,
        ST_ENTER,
        ST_PD,
        ST_EXIT,
        ST_DLL_ON
    } pd_state_e;

    typedef enum logic [1:0] {
        CMD_PASS  = 2'b00,
        CMD_NOP   = 2'b01,
        CMD_DESEL = 2'b10
    } pd_cmd_e;

    typedef struct packed {
        pd_state_e st;
        logic      cke;
        pd_cmd_e   cmd;
        logic      pd_act;
        logic      pd_type;
        logic      dll_down;
        logic      off_pls;
        logic      on_pls;
    } seq_regs_t;

endpackage

// File: rtl/ddr_pd_resid_timer.sv
module ddr_pd_resid_timer #(
    parameter int unsigned RESID_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [RESID_W-1:0] limit,
    output logic               expired
);
    logic [RESID_W-1:0] cnt_d, cnt_q;
    logic [RESID_W:0]   cnt_inc;

    always_comb begin
        cnt_inc = {1'b0, cnt_q} + (RESID_W+1)'(1);
        if (!run)
            cnt_d = '0;
        else if (cnt_q == '1)
            cnt_d = cnt_q;
        else
            cnt_d = cnt_inc[RESID_W-1:0];
        expired = run && (limit != '0) && (cnt_inc == {1'b0, limit});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R8: the count restarts whenever power-down is left
    a_r8_count_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt_q == '0);

endmodule

// File: rtl/ddr_pd_lock_timer.sv
module ddr_pd_lock_timer #(
    parameter int unsigned LOCK_CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic locked
);
    localparam int unsigned CW = $clog2(LOCK_CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (start)
            cnt_d = CW'(LOCK_CYCLES - 1);
        else if (cnt_q != '0)
            cnt_d = cnt_q - CW'(1);
        else
            cnt_d = '0;
        locked = (cnt_q != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R10: a relock request always opens a lockout window
    a_r10_lock_starts: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> locked);

endmodule

// File: rtl/ddr_pd_fsm.sv
module ddr_pd_fsm
    import ddr_pd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pd_req,
    input  logic      busy,
    input  logic      open_any,
    input  logic      refresh_due,
    input  logic      dll_off_en,
    input  logic      resid_expired,
    output pd_state_e state,
    output logic      cke,
    output pd_cmd_e   cmd,
    output logic      pd_act,
    output logic      pd_type,
    output logic      dll_down,
    output logic      dll_off_req,
    output logic      dll_on_req
);
    seq_regs_t r_d, r_q;
    logic      accept;
    logic      leave;

    always_comb begin
        r_d         = r_q;
        r_d.off_pls = 1'b0;
        r_d.on_pls  = 1'b0;
        accept      = pd_req && !busy && !refresh_due;
        leave       = !pd_req || refresh_due || resid_expired;
        unique case (r_q.st)
            ST_IDLE: begin
                if (accept) begin
                    if (dll_off_en) begin
                        r_d.st       = ST_DLL_OFF;
                        r_d.dll_down = 1'b1;
                        r_d.off_pls  = 1'b1;
                    end else begin
                        r_d.st      = ST_ENTER;
                        r_d.cke     = 1'b0;
                        r_d.cmd     = CMD_NOP;
                        r_d.pd_act  = 1'b1;
                        r_d.pd_type = open_any;
                    end
                end
            end
            ST_DLL_OFF: begin
                if (!busy) begin
                    r_d.st      = ST_ENTER;
                    r_d.cke     = 1'b0;
                    r_d.cmd     = CMD_NOP;
                    r_d.pd_act  = 1'b1;
                    r_d.pd_type = open_any;
                end
            end
            ST_ENTER: begin
                r_d.st  = ST_PD;
                r_d.cmd = CMD_DESEL;
            end
            ST_PD: begin
                if (leave) begin
                    r_d.st     = ST_EXIT;
                    r_d.cke    = 1'b1;
                    r_d.cmd    = CMD_NOP;
                    r_d.pd_act = 1'b0;
                end
            end
            ST_EXIT: begin
                r_d.cmd = CMD_PASS;
                if (r_q.dll_down) begin
                    r_d.st     = ST_DLL_ON;
                    r_d.on_pls = 1'b1;
                end else begin
                    r_d.st = ST_IDLE;
                end
            end
            ST_DLL_ON: begin
                r_d.st       = ST_IDLE;
                r_d.dll_down = 1'b0;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st       <= ST_IDLE;
            r_q.cke      <= 1'b1;
            r_q.cmd      <= CMD_PASS;
            r_q.pd_act   <= 1'b0;
            r_q.pd_type  <= 1'b0;
            r_q.dll_down <= 1'b0;
            r_q.off_pls  <= 1'b0;
            r_q.on_pls   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state       = r_q.st;
    assign cke         = r_q.cke;
    assign cmd         = r_q.cmd;
    assign pd_act      = r_q.pd_act;
    assign pd_type     = r_q.pd_type;
    assign dll_down    = r_q.dll_down;
    assign dll_off_req = r_q.off_pls;
    assign dll_on_req  = r_q.on_pls;

    // R3: cke only falls after an edge that saw the engine idle
    a_r3_entry_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> $past(!busy));

    // R5: while asleep the bus is held at DESELECT with cke low
    a_r5_desel_in_pd: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_PD) |-> (!cke && cmd == CMD_DESEL));

    // R6: wake-up is always accompanied by a NOP
    a_r6_exit_with_nop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> cmd == CMD_NOP);

    // R7: a due refresh pulls the device out at the next edge
    a_r7_refresh_forces_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_PD && refresh_due) |=> cke);

    // R9: the DLL-off request is a single-cycle pulse
    a_r9_off_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        dll_off_req |=> !dll_off_req);

endmodule

// File: rtl/ddr_pd_seq.sv
module ddr_pd_seq
    import ddr_pd_pkg::*;
#(
    parameter int unsigned NUM_BANKS   = 4,
    parameter int unsigned RESID_W     = 16,
    parameter int unsigned LOCK_CYCLES = 200
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pd_req,
    input  logic                 engine_busy,
    input  logic [NUM_BANKS-1:0] bank_open,
    input  logic                 refresh_due,
    input  logic                 dll_off_en,
    input  logic [RESID_W-1:0]   max_resid,
    output logic                 cke,
    output logic [1:0]           cmd_ctl,
    output logic                 dll_off_req,
    output logic                 dll_on_req,
    output logic                 pd_active,
    output logic                 pd_type,
    output logic                 read_allowed,
    output logic                 cmd_ready
);
    pd_state_e st;
    pd_cmd_e   cmd;
    logic      dll_down;
    logic      resid_expired;
    logic      lock_busy;
    logic      open_any;

    assign open_any = |bank_open;

    ddr_pd_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .pd_req        (pd_req),
        .busy          (engine_busy),
        .open_any      (open_any),
        .refresh_due   (refresh_due),
        .dll_off_en    (dll_off_en),
        .resid_expired (resid_expired),
        .state         (st),
        .cke           (cke),
        .cmd           (cmd),
        .pd_act        (pd_active),
        .pd_type       (pd_type),
        .dll_down      (dll_down),
        .dll_off_req   (dll_off_req),
        .dll_on_req    (dll_on_req)
    );

    ddr_pd_resid_timer #(.RESID_W(RESID_W)) u_resid (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (st == ST_PD),
        .limit   (max_resid),
        .expired (resid_expired)
    );

    ddr_pd_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (st == ST_DLL_ON),
        .locked (lock_busy)
    );

    assign cmd_ctl      = cmd;
    assign cmd_ready    = (cmd == CMD_PASS);
    assign read_allowed = cmd_ready && !dll_down && !lock_busy;

    // R8: an expired residency limit always ends power-down
    a_r8_expiry_leaves_pd: assert property (@(posedge clk) disable iff (!rst_n)
        resid_expired |=> (st == ST_EXIT));

    // R10: no READ window while a relock pulse is outstanding
    a_r10_no_read_after_on: assert property (@(posedge clk) disable iff (!rst_n)
        dll_on_req |=> !read_allowed);

endmodule

// File: tb/ddr_pd_seq_tb.sv
module ddr_pd_seq_tb;
    localparam int NB   = 4;
    localparam int RW   = 16;
    localparam int LOCK = 200;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pd_req = 1'b0;
    logic          engine_busy = 1'b0;
    logic [NB-1:0] bank_open = '0;
    logic          refresh_due = 1'b0;
    logic          dll_off_en = 1'b0;
    logic [RW-1:0] max_resid = '0;
    logic          cke;
    logic [1:0]    cmd_ctl;
    logic          dll_off_req, dll_on_req, pd_active, pd_type, read_allowed, cmd_ready;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    ddr_pd_seq #(.NUM_BANKS(NB), .RESID_W(RW), .LOCK_CYCLES(LOCK)) u_dut (
        .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .engine_busy(engine_busy),
        .bank_open(bank_open), .refresh_due(refresh_due), .dll_off_en(dll_off_en),
        .max_resid(max_resid), .cke(cke), .cmd_ctl(cmd_ctl), .dll_off_req(dll_off_req),
        .dll_on_req(dll_on_req), .pd_active(pd_active), .pd_type(pd_type),
        .read_allowed(read_allowed), .cmd_ready(cmd_ready)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic nxt();
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        repeat (3) nxt();
        rst_n = 1'b1;
        nxt();
        // R1 reset state
        chk("R1 cke", cke, 1);
        chk("R1 cmd", cmd_ctl, 0);
        chk("R1 pd_active", pd_active, 0);
        chk("R1 cmd_ready", cmd_ready, 1);
        chk("R1 read_allowed", read_allowed, 1);
        chk("R1 dll pulses", {dll_off_req, dll_on_req}, 0);

        // R2 R4 R5 R6: all bank bitmaps
        for (int bm = 0; bm < (1 << NB); bm++) begin
            bank_open = NB'(bm);
            pd_req = 1'b1;
            nxt();
            chk("R2 cke low", cke, 0);
            chk("R2 nop", cmd_ctl, 1);
            chk("R2 pd_active", pd_active, 1);
            chk("R4 pd_type", pd_type, (bm != 0) ? 1 : 0);
            bank_open = ~NB'(bm);
            nxt();
            chk("R5 cke", cke, 0);
            chk("R5 deselect", cmd_ctl, 2);
            chk("R5 ready/read", {cmd_ready, read_allowed}, 0);
            chk("R4 pd_type held", pd_type, (bm != 0) ? 1 : 0);
            pd_req = 1'b0;
            nxt();
            chk("R6 cke high", cke, 1);
            chk("R6 nop", cmd_ctl, 1);
            chk("R6 pd_active", pd_active, 0);
            nxt();
            chk("R6 pass", cmd_ctl, 0);
            chk("R6 cmd_ready", cmd_ready, 1);
        end
        bank_open = '0;

        // R3: busy holds the request
        for (int d = 1; d <= 4; d++) begin
            engine_busy = 1'b1;
            pd_req = 1'b1;
            n = 0;
            for (int i = 0; i < d; i++) begin
                nxt();
                if (cke) n++;
            end
            chk("R3 held while busy", n, d);
            engine_busy = 1'b0;
            nxt();
            chk("R3 entry after busy", cke, 0);
            pd_req = 1'b0;
            repeat (3) nxt();
        end

        // R7: refresh blocks entry and forces exit
        refresh_due = 1'b1;
        pd_req = 1'b1;
        n = 0;
        repeat (3) begin nxt(); if (cke) n++; end
        chk("R7 no entry with refresh", n, 3);
        refresh_due = 1'b0;
        nxt();
        chk("R7 entry after refresh drop", cke, 0);
        repeat (3) nxt();
        refresh_due = 1'b1;
        nxt();
        chk("R7 forced exit cke", cke, 1);
        chk("R7 forced exit nop", cmd_ctl, 1);
        nxt();
        chk("R7 stays idle", cke, 1);
        pd_req = 1'b0;
        refresh_due = 1'b0;
        nxt();

        // R8: residency limit sweep
        for (int m = 1; m <= 6; m++) begin
            max_resid = RW'(m);
            pd_req = 1'b1;
            n = 0;
            nxt();
            while (!cke && n < 200) begin n++; nxt(); end
            chk("R8 low cycles", n, m + 1);
            pd_req = 1'b0;
            nxt();
        end
        max_resid = '0;
        pd_req = 1'b1;
        n = 0;
        repeat (50) begin nxt(); if (!cke) n++; end
        chk("R8 unlimited", n, 50);
        pd_req = 1'b0;
        repeat (3) nxt();

        // R9 R10: DLL-off path
        dll_off_en = 1'b1;
        pd_req = 1'b1;
        nxt();
        chk("R9 off pulse", dll_off_req, 1);
        chk("R9 cke high", cke, 1);
        chk("R9 cmd_ready", cmd_ready, 1);
        chk("R9 read blocked", read_allowed, 0);
        engine_busy = 1'b1;
        nxt();
        chk("R9 single pulse", dll_off_req, 0);
        chk("R9 wait busy", cke, 1);
        engine_busy = 1'b0;
        nxt();
        chk("R9 entry", cke, 0);
        nxt();
        pd_req = 1'b0;
        dll_off_en = 1'b0;
        nxt();
        chk("R10 exit nop", cmd_ctl, 1);
        chk("R10 read blocked at exit", read_allowed, 0);
        nxt();
        chk("R10 on pulse", dll_on_req, 1);
        chk("R10 cmd_ready", cmd_ready, 1);
        n = 0;
        while (!read_allowed && n < 1000) begin n++; nxt(); end
        chk("R10 lockout length", n, LOCK);
        chk("R10 on pulse single", dll_on_req, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule